// File: doc/BRIEF.md
# Overcurrent Shutdown Off-Time Timer

This block turns a digital overcurrent flag from a current-sense comparator into a shutdown level. The level forces every gate drive of a motor bridge off. The first detection starts a fixed off-time measured in clock cycles. The off-time runs to its end even if the flag clears early. Fresh comparator activity during the off-time neither restarts nor lengthens it.

When the off-time expires, the block checks the flag. If the overcurrent is still present, the shutdown continues for as long as the flag stays high. It ends on the first cycle the synchronised flag reads low.

The off-time is set by two parameters: the clock rate in cycles per microsecond, and a select between a short (10 µs) window and a long (100 µs) window. The flag is asynchronous to the block clock and passes through a two-flop synchroniser. Besides the shutdown level, the block drives an active-low fault contribution, which a neighbour can merge with other fault sources.

Top module: `oc_shutdown_timer`

## Requirements
- R1: While rst_ni is low, and after its release with no overcurrent, oc_active_o is 0 and oc_fault_no is 1.
- R2: When oc_flag_i is first sampled high at clock edge k from the idle state, oc_active_o goes high after edge k+2 (two synchroniser stages plus the state register).
- R3: An overcurrent pulse of at most OFF_CYCLES clocks keeps oc_active_o high for exactly OFF_CYCLES cycles. OFF_CYCLES = CLK_PER_US*10 when LONG_OFF is 0, and CLK_PER_US*100 when LONG_OFF is 1.
- R4: Both settings of LONG_OFF produce their own window length from the same flag stimulus.
- R5: Flag pulses that arrive during the off-time neither restart nor extend it. The shutdown length stays OFF_CYCLES when the flag is low at the window end.
- R6: A flag that is high when the window ends extends the shutdown. For a single pulse of P > OFF_CYCLES clocks, oc_active_o is high for exactly P cycles.
- R7: After the window, release follows the fall of the flag. oc_active_o goes low after the third edge that samples the flag low, matching the entry latency of R2.
- R8: oc_fault_no is the inverse of oc_active_o in every cycle.
- R9: A detection made on the first idle cycle after a release starts a fresh full window.
- R10: Asserting rst_ni low during a shutdown clears oc_active_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_flag_i | input | 1 | Overcurrent comparator flag, asynchronous, active high |
| oc_active_o | output | 1 | High while all gate drives must be held off |
| oc_fault_no | output | 1 | Fault contribution, low during shutdown |

## Verification
The bench goes after pulse lengths on either side of the window boundary: exactly OFF_CYCLES and one clock more. A design that samples the flag a cycle early or late at the window end would return a count that is off by one. Second pulses placed inside the window, and one that runs past its end, expose a retriggerable timer: it would report a longer shutdown where the expected one is exactly the window. A pulse issued on the first cycle after a release, and a reset in mid-window, catch designs that lose the fresh window or clear the shutdown only on a clock edge.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [1:0] {
    OC_IDLE   = 2'd0,
    OC_TIMING = 2'd1,
    OC_HOLD   = 2'd2
  } oc_state_e;

  function automatic int unsigned off_cycles(input int unsigned clk_per_us, input bit long_off);
    return clk_per_us * (long_off ? 100 : 10);
  endfunction
endpackage

// File: rtl/oc_sync.sv
`timescale 1ns/1ps
module oc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= sr_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/oc_off_timer.sv
`timescale 1ns/1ps
module oc_off_timer #(
  parameter int unsigned OFF_CYCLES = 20,
  localparam int unsigned CNT_W = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(OFF_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (load_i)                      cnt_o <= LOAD_VAL;
    else if (tick_i && cnt_o != '0)       cnt_o <= cnt_o - 1'b1;
  end

  assign expired_o = (cnt_o == '0);
endmodule

// File: rtl/oc_fsm.sv
`timescale 1ns/1ps
module oc_fsm
  import oc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flag_i,
  input  logic      expired_i,
  output logic      load_o,
  output logic      tick_o,
  output oc_state_e state_o
);
  oc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    tick_o  = 1'b0;
    unique case (state_q)
      OC_IDLE: begin
        if (flag_i) begin
          state_d = OC_TIMING;
          load_o  = 1'b1;
        end
      end
      OC_TIMING: begin
        // flag is ignored until the window has run out
        if (expired_i) state_d = flag_i ? OC_HOLD : OC_IDLE;
        else           tick_o  = 1'b1;
      end
      OC_HOLD: begin
        if (!flag_i) state_d = OC_IDLE;
      end
      default: state_d = OC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OC_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/oc_shutdown_timer.sv
`timescale 1ns/1ps
module oc_shutdown_timer
  import oc_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 100,
  parameter bit          LONG_OFF    = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_flag_i,
  output logic oc_active_o,
  output logic oc_fault_no
);
  localparam int unsigned OFF_CYCLES = off_cycles(CLK_PER_US, LONG_OFF);
  localparam int unsigned CNT_W = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;

  logic             flag_sync;
  logic             load;
  logic             tick;
  logic             expired;
  logic [CNT_W-1:0] cnt;
  oc_state_e        state;

  oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (oc_flag_i),
    .q_o    (flag_sync)
  );

  oc_off_timer #(.OFF_CYCLES(OFF_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .expired_o (expired)
  );

  oc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_i    (flag_sync),
    .expired_i (expired),
    .load_o    (load),
    .tick_o    (tick),
    .state_o   (state)
  );

  assign oc_active_o = (state != OC_IDLE);
  assign oc_fault_no = ~oc_active_o;
endmodule

// File: rtl/oc_shutdown_timer_chk.sv
`timescale 1ns/1ps
module oc_shutdown_timer_chk
  import oc_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 20,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flag_s,
  input oc_state_e        state,
  input logic [CNT_W-1:0] cnt,
  input logic             oc_active_o
);
  logic [31:0] win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 win_cnt <= '0;
    else if (state == OC_TIMING) win_cnt <= win_cnt + 1;
    else                         win_cnt <= '0;
  end

  // R2
  rise_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_active_o) |-> $past(flag_s));

  // R3
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == OC_TIMING && state != OC_TIMING) |-> win_cnt == OFF_CYCLES);

  // R5
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == OC_TIMING && $past(state) == OC_TIMING) |-> cnt == $past(cnt) - 1'b1);

  // R6
  extend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == OC_TIMING && cnt == '0 && flag_s) |=> state == OC_HOLD);

  // R6
  hold_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == OC_HOLD && flag_s) |=> state == OC_HOLD);

  // R7
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == OC_HOLD && !flag_s) |=> !oc_active_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == OC_IDLE && !flag_s) |=> !oc_active_o);
endmodule

bind oc_shutdown_timer oc_shutdown_timer_chk #(
  .OFF_CYCLES (OFF_CYCLES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flag_s      (flag_sync),
  .state       (state),
  .cnt         (cnt),
  .oc_active_o (oc_active_o)
);

// File: tb/oc_shutdown_timer_bench.sv
`timescale 1ns/1ps
module oc_shutdown_timer_bench;
  localparam int unsigned CPU = 2;
  localparam int NS = 20;
  localparam int NL = 200;
  localparam int NVEC = 9;
  localparam int LIMIT = 700;

  // {first pulse, second start, second len, expected short, expected long}
  localparam int VEC [NVEC][5] = '{
    '{1,   0,  0, 20,  200},
    '{5,   0,  0, 20,  200},
    '{20,  0,  0, 20,  200},
    '{21,  0,  0, 21,  200},
    '{35,  0,  0, 35,  200},
    '{3,   8,  4, 20,  200},
    '{3,  12,  6, 20,  200},
    '{3,  15, 20, 35,  200},
    '{250, 0,  0, 250, 250}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag = 1'b0;
  logic act_s, flt_s, act_l, flt_l;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  oc_shutdown_timer #(.CLK_PER_US(CPU), .LONG_OFF(1'b0)) u_oc_shutdown_timer (
    .clk_i(clk), .rst_ni(rst_n), .oc_flag_i(flag),
    .oc_active_o(act_s), .oc_fault_no(flt_s));

  oc_shutdown_timer #(.CLK_PER_US(CPU), .LONG_OFF(1'b1)) u_oc_shutdown_timer_long (
    .clk_i(clk), .rst_ni(rst_n), .oc_flag_i(flag),
    .oc_active_o(act_l), .oc_fault_no(flt_l));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flag high for edges 1..p1 and s2+1..s2+p2, counted from the call
  task automatic run_pulse(input int p1, input int s2, input int p2,
                           input int exp_s, input int exp_l, input string tag);
    int cnt_s = 0, cnt_l = 0, first_s = 0, first_l = 0, bad_flt = 0;
    bit seen_s = 0, seen_l = 0;
    @(negedge clk);
    flag = (p1 > 0);
    for (int i = 1; i <= LIMIT; i++) begin
      @(negedge clk);
      if (flt_s !== ~act_s || flt_l !== ~act_l) bad_flt++;
      if (act_s) begin cnt_s++; if (!seen_s) first_s = i; seen_s = 1; end
      if (act_l) begin cnt_l++; if (!seen_l) first_l = i; seen_l = 1; end
      flag = (i < p1) || (p2 > 0 && i >= s2 && i < s2 + p2);
      if (seen_s && seen_l && !act_s && !act_l && !flag) break;
    end
    flag = 1'b0;
    check(cnt_s == exp_s, {tag, " short window"}, cnt_s, exp_s);
    check(cnt_l == exp_l, {tag, " long window R4"}, cnt_l, exp_l);
    check(first_s == 3 && first_l == 3, "R2 entry latency", first_s * 1000 + first_l, 3003);
    check(bad_flt == 0, "R8 fault inverse", bad_flt, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #2;
    // R1 during reset
    check(act_s == 0 && flt_s == 1 && act_l == 0 && flt_l == 1, "R1 in reset", act_s, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(act_s == 0 && flt_s == 1 && act_l == 0 && flt_l == 1, "R1 after reset", act_s, 0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      if (VEC[v][2] != 0) tag = "R5 retrigger ignored";
      else if (VEC[v][0] > NS) tag = "R6 R7 extend";
      else tag = "R3 window";
      run_pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], tag);
      repeat (3) @(negedge clk);
    end

    // R9: new detection right after release, no idle gap
    run_pulse(2, 0, 0, NS, NL, "R9 fresh window A");
    run_pulse(2, 0, 0, NS, NL, "R9 fresh window B");

    // R10: asynchronous reset mid-shutdown
    @(negedge clk);
    flag = 1'b1;
    repeat (8) @(negedge clk);
    flag = 1'b0;
    check(act_s == 1 && act_l == 1, "R10 active before reset", act_s, 1);
    #1 rst_n = 1'b0;
    #1 check(act_s == 0 && act_l == 0 && flt_s == 1, "R10 async clear", act_s, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(act_s == 0 && act_l == 0, "R1 idle after reset release", act_s, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule